// File: doc/BRIEF.md
# SPI Frame Transfer Counter

This block sits beside the shift engine of a queued SPI master. It keeps a 16-bit count of completed frames, and it gives software a start/stop control. A stop request never cuts a frame short: it takes effect at the next frame boundary. The shift engine reports two events. The first is the cycle in which the final bit of a frame leaves the shifter. The second is the cycle in which a new frame begins, together with the clear-count flag of the command that owns that frame. In return the block tells the engine whether it may start another frame.

Software reaches the block through a small write port with one select bit. With the select at 0 the port writes the count register, and the count lives in the upper half of the 32-bit word. With the select at 1 it writes the control register, whose halt flag is data bit 0. The read side shows the count in bits 31:16, and bits 15:0 always read as zero.

A three-state controller does the sequencing. STOPPED (the state after reset) moves to RUNNING when halt is 0 and frames are available. RUNNING moves to STOPPED when halt is 1 and no frame is in flight, or when the last bit arrives while halt is 1. RUNNING moves to DRAIN when halt is 1 and a frame is in flight. DRAIN moves to STOPPED on the last bit while halt is still 1. DRAIN moves back to RUNNING when halt is cleared.

Top module: `spi_frame_counter`

## Requirements
- R1: After reset the read word is 0x00000000, halt is 1, the state is STOPPED, and both `running_o` and `frame_permit_o` are 0.
- R2: The read word carries the count in bits 31:16, and bits 15:0 are always zero.
- R3: A pulse on `frame_last_i` increments the count. The new value is visible one cycle after the sampling edge.
- R4: Incrementing from 65535 gives 0.
- R5: A write with `wr_sel_i`=0 while `running_o` is 0 loads `wr_data_i[31:16]` into the count. Bits 15:0 of the data are discarded.
- R6: A count write while `running_o` is 1 leaves the count unchanged.
- R7: `frame_start_i` together with `clr_cnt_i`=1 zeroes the count in the next cycle, and that frame's last bit then brings it to 1.
- R8: When events coincide, an accepted count write beats a clear, and a clear beats an increment.
- R9: A write with `wr_sel_i`=1 sets halt to `wr_data_i[0]`. With halt at 0 and `frames_avail_i` at 1, the block enters RUNNING two cycles after the write edge, and `running_o` and `frame_permit_o` are both 1 there.
- R10: Halt set while a frame is in flight moves the block to DRAIN. In DRAIN `frame_permit_o` is 0 and `running_o` stays 1 until the last bit. The block is STOPPED the cycle after that bit, and the count includes that frame.
- R11: Halt set in RUNNING with no frame in flight moves the block to STOPPED, two cycles after the write edge.
- R12: Clearing halt during DRAIN returns the block to RUNNING with `frame_permit_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start_i | input | 1 | First cycle of a new frame |
| clr_cnt_i | input | 1 | Clear-count flag of the command that starts the frame |
| frame_last_i | input | 1 | Last bit of the current frame has been shifted out |
| frames_avail_i | input | 1 | Queue holds frames to send |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 = count register, 1 = control register |
| wr_data_i | input | 32 | Write data |
| cnt_rd_o | output | 32 | Count register read value |
| running_o | output | 1 | Block is in RUNNING or DRAIN |
| frame_permit_o | output | 1 | Shift engine may start a new frame |

## Verification
Every count result (increment, preset, clear and wrap) appears one cycle after the edge that samples the strobe. The bench therefore drives each strobe just after an edge and reads `cnt_rd_o` one edge later. A halt change takes two cycles to reach `running_o` and `frame_permit_o`: one to store the halt flag and one for the state register. The halt scenarios therefore step twice before they check. The drain scenario also samples several cycles before the last bit, so it can confirm that `running_o` has not fallen early.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    typedef enum logic [1:0] {
        ST_STOPPED = 2'd0,
        ST_RUNNING = 2'd1,
        ST_DRAIN   = 2'd2
    } run_state_e;

    typedef enum logic {
        SEL_COUNT = 1'b0,
        SEL_CTRL  = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/sfc_count_reg.sv
module sfc_count_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clr_en,
    input  logic             inc_en,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_d;

    // Priority: preset write, then frame-start clear, then last-bit increment.
    always_comb begin
        cnt_d = cnt_q;
        if (load_en)
            cnt_d = load_val;
        else if (clr_en)
            cnt_d = '0;
        else if (inc_en)
            cnt_d = cnt_q + ONE;   // natural wrap at full scale
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sfc_run_ctl.sv
module sfc_run_ctl
    import sfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt_wr,
    input  logic halt_val,
    input  logic frames_avail,
    input  logic frame_start,
    input  logic frame_last,
    output logic running,
    output logic permit
);
    run_state_e state_q, state_d;
    logic       halt_q;
    logic       in_frame_q;

    // Halt flag resets to 1 so nothing is sent until software releases it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            halt_q <= 1'b1;
        else if (halt_wr)
            halt_q <= halt_val;
    end

    // Frame-in-flight tracker: a start opens a frame, the last bit closes it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            in_frame_q <= 1'b0;
        else if (frame_start)
            in_frame_q <= 1'b1;
        else if (frame_last)
            in_frame_q <= 1'b0;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: begin
                if (!halt_q && frames_avail)
                    state_d = ST_RUNNING;
            end
            ST_RUNNING: begin
                if (halt_q) begin
                    if (frame_last)
                        state_d = ST_STOPPED;
                    else if (in_frame_q || frame_start)
                        state_d = ST_DRAIN;
                    else
                        state_d = ST_STOPPED;
                end
            end
            ST_DRAIN: begin
                if (!halt_q)
                    state_d = ST_RUNNING;
                else if (frame_last)
                    state_d = ST_STOPPED;
            end
            default: state_d = ST_STOPPED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_STOPPED;
        else
            state_q <= state_d;
    end

    always_comb begin
        running = 1'b0;
        permit  = 1'b0;
        unique case (state_q)
            ST_STOPPED: begin
                running = 1'b0;
                permit  = 1'b0;
            end
            ST_RUNNING: begin
                running = 1'b1;
                permit  = 1'b1;
            end
            ST_DRAIN: begin
                running = 1'b1;
                permit  = 1'b0;
            end
            default: begin
                running = 1'b0;
                permit  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/spi_frame_counter.sv
module spi_frame_counter
    import sfc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start_i,
    input  logic             clr_cnt_i,
    input  logic             frame_last_i,
    input  logic             frames_avail_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] cnt_rd_o,
    output logic             running_o,
    output logic             frame_permit_o
);
    localparam int CNT_LSB = REG_W - CNT_W;

    logic             cnt_load;
    logic             halt_wr;
    logic             cnt_clr;
    logic [CNT_W-1:0] cnt_val;
    logic             unused_wr_bits;

    assign unused_wr_bits = ^wr_data_i[CNT_LSB-1:1];

    // Count presets are accepted only while the block is not running.
    assign cnt_load = wr_en_i && (wr_sel_i == SEL_COUNT) && !running_o;
    assign halt_wr  = wr_en_i && (wr_sel_i == SEL_CTRL);
    assign cnt_clr  = frame_start_i && clr_cnt_i;

    sfc_count_reg #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (cnt_load),
        .load_val (wr_data_i[REG_W-1:CNT_LSB]),
        .clr_en   (cnt_clr),
        .inc_en   (frame_last_i),
        .cnt_q    (cnt_val)
    );

    sfc_run_ctl u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .halt_wr      (halt_wr),
        .halt_val     (wr_data_i[0]),
        .frames_avail (frames_avail_i),
        .frame_start  (frame_start_i),
        .frame_last   (frame_last_i),
        .running      (running_o),
        .permit       (frame_permit_o)
    );

    generate
        if (CNT_LSB > 0) begin : g_pad
            assign cnt_rd_o = {cnt_val, {CNT_LSB{1'b0}}};
        end else begin : g_nopad
            assign cnt_rd_o = cnt_val;
        end
    endgenerate
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
    parameter int CNT_W = 16,
    parameter int REG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start_i,
    input logic             clr_cnt_i,
    input logic             frame_last_i,
    input logic             wr_en_i,
    input logic             wr_sel_i,
    input logic [REG_W-1:0] wr_data_i,
    input logic [REG_W-1:0] cnt_rd_o,
    input logic             running_o,
    input logic             frame_permit_o
);
    localparam int CNT_LSB = REG_W - CNT_W;

    logic             wr_cnt;
    logic             clr_ev;
    logic [CNT_W-1:0] cnt_f;

    assign wr_cnt = wr_en_i && !wr_sel_i;
    assign clr_ev = frame_start_i && clr_cnt_i;
    assign cnt_f  = cnt_rd_o[REG_W-1:CNT_LSB];

    // R3 R4
    inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_last_i && !clr_ev && !(wr_cnt && !running_o))
        |=> cnt_f == CNT_W'($past(cnt_f) + 1'b1));

    // R5
    preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt && !running_o) |=> cnt_f == $past(wr_data_i[REG_W-1:CNT_LSB]));

    // R6
    ignore_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt && running_o && !frame_last_i && !clr_ev) |=> $stable(cnt_rd_o));

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ev && !(wr_cnt && !running_o)) |=> cnt_f == '0);

    // R10
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && !frame_permit_o && !frame_last_i) |=> running_o);

    // R1
    permit_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running_o |-> !frame_permit_o);
endmodule

bind spi_frame_counter sfc_checker #(.CNT_W(CNT_W), .REG_W(REG_W)) u_sfc_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_start_i  (frame_start_i),
    .clr_cnt_i      (clr_cnt_i),
    .frame_last_i   (frame_last_i),
    .wr_en_i        (wr_en_i),
    .wr_sel_i       (wr_sel_i),
    .wr_data_i      (wr_data_i),
    .cnt_rd_o       (cnt_rd_o),
    .running_o      (running_o),
    .frame_permit_o (frame_permit_o)
);

// File: tb/test_spi_frame_counter.sv
module test_spi_frame_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start_i = 1'b0;
    logic        clr_cnt_i = 1'b0;
    logic        frame_last_i = 1'b0;
    logic        frames_avail_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic        wr_sel_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] cnt_rd_o;
    logic        running_o;
    logic        frame_permit_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_frame_counter i_spi_frame_counter (
        .clk(clk), .rst_n(rst_n),
        .frame_start_i(frame_start_i), .clr_cnt_i(clr_cnt_i),
        .frame_last_i(frame_last_i), .frames_avail_i(frames_avail_i),
        .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .cnt_rd_o(cnt_rd_o), .running_o(running_o), .frame_permit_o(frame_permit_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic sel, logic [31:0] data);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
        tick();
        wr_en_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic set_halt(logic h);
        reg_write(1'b1, {31'd0, h});
        tick();
    endtask

    task automatic do_start(logic clr);
        frame_start_i = 1'b1; clr_cnt_i = clr;
        tick();
        frame_start_i = 1'b0; clr_cnt_i = 1'b0;
    endtask

    task automatic do_last();
        frame_last_i = 1'b1;
        tick();
        frame_last_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 count", cnt_rd_o, 32'h0);
        check("R1 running", {31'd0, running_o}, 32'd0);
        check("R1 permit", {31'd0, frame_permit_o}, 32'd0);
        frames_avail_i = 1'b1;
        tick(); tick();
        check("R1 halt set stays stopped", {31'd0, running_o}, 32'd0);
    endtask

    task automatic t_preset();
        reg_write(1'b0, 32'hABCD_5A5A);
        check("R5 R2 preset", cnt_rd_o, 32'hABCD_0000);
        wr_en_i = 1'b1; wr_sel_i = 1'b0; wr_data_i = 32'h1234_0000; frame_last_i = 1'b1;
        tick();
        wr_en_i = 1'b0; frame_last_i = 1'b0;
        check("R8 write beats increment", cnt_rd_o, 32'h1234_0000);
    endtask

    task automatic t_run_count();
        set_halt(1'b0);
        check("R9 running", {31'd0, running_o}, 32'd1);
        check("R9 permit", {31'd0, frame_permit_o}, 32'd1);
        reg_write(1'b0, 32'h7777_0000);
        check("R6 write ignored", cnt_rd_o, 32'h1234_0000);
        do_start(1'b0);
        tick();
        check("R3 no change mid-frame", cnt_rd_o, 32'h1234_0000);
        do_last();
        check("R3 increment", cnt_rd_o, 32'h1235_0000);
        do_start(1'b1);
        check("R7 clear at start", cnt_rd_o, 32'h0);
        tick();
        do_last();
        check("R7 count after clear", cnt_rd_o, 32'h0001_0000);
        frame_start_i = 1'b1; clr_cnt_i = 1'b1; frame_last_i = 1'b1;
        tick();
        frame_start_i = 1'b0; clr_cnt_i = 1'b0; frame_last_i = 1'b0;
        check("R8 clear beats increment", cnt_rd_o, 32'h0);
        do_last();
    endtask

    task automatic t_idle_halt();
        set_halt(1'b1);
        check("R11 stopped", {31'd0, running_o}, 32'd0);
        check("R11 permit", {31'd0, frame_permit_o}, 32'd0);
    endtask

    task automatic t_wrap();
        reg_write(1'b0, 32'hFFFE_0000);
        set_halt(1'b0);
        do_start(1'b0); do_last();
        check("R4 at max", cnt_rd_o, 32'hFFFF_0000);
        do_start(1'b0); do_last();
        check("R4 wrap", cnt_rd_o, 32'h0);
    endtask

    task automatic t_drain();
        do_start(1'b0);
        set_halt(1'b1);
        check("R10 drain permit", {31'd0, frame_permit_o}, 32'd0);
        for (int i = 0; i < 4; i++) begin
            tick();
            check("R10 still running", {31'd0, running_o}, 32'd1);
        end
        do_last();
        check("R10 stopped after last", {31'd0, running_o}, 32'd0);
        check("R10 frame counted", cnt_rd_o, 32'h0001_0000);
    endtask

    task automatic t_resume();
        set_halt(1'b0);
        do_start(1'b0);
        set_halt(1'b1);
        check("R12 in drain", {31'd0, frame_permit_o}, 32'd0);
        set_halt(1'b0);
        check("R12 permit back", {31'd0, frame_permit_o}, 32'd1);
        check("R12 running", {31'd0, running_o}, 32'd1);
        do_last();
        check("R12 still running", {31'd0, running_o}, 32'd1);
        check("R12 count", cnt_rd_o, 32'h0002_0000);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_preset();
        t_run_count();
        t_idle_halt();
        t_wrap();
        t_drain();
        t_resume();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule